// File: doc/BRIEF.md
# VPW Pulse-Width Symbol Decoder

This block listens to one single-wire, variable-pulse-width bus line. The line must already be synchronised to the clock. A one-cycle microsecond strobe provides the timebase. The block measures the interval between line edges in microseconds. It waits for a start-of-frame pulse at the active level, and the width of that pulse sets the rate of the frame: normal (1x) or fast (4x). At 4x, every time window for the frame is a quarter of its 1x value.

In the data phase, each pulse is classified as short or long. Both the width and the line level during the pulse decide the bit value. Bits are collected most significant bit first, and every eighth bit gives one byte. A frame ends when the line stays quiet for longer than the gap time. A pulse width that matches no window and is not a tiny glitch is reported as an error, and the block goes back to hunting for a start pulse.

Every result leaves the block as a one-clock strobe. The byte output has a valid flag but no ready input. The bus cannot be paused, so there is no back-pressure: the consumer must take each byte in the cycle where `byte_valid` is high.

Top module: `vpw_symbol_decoder`

## Requirements
- R1: While hunting, an active-level pulse of 164 µs up to but not including 245 µs raises `sof_pulse` for one clock with `speed_4x` = 0. That speed flag is held until the next start pulse.
- R2: While hunting, an active-level pulse of 41 µs up to but not including 61 µs, when no 1x start applies, raises `sof_pulse` with `speed_4x` = 1. For the rest of that frame, every symbol and gap limit is divided by 4 (integer division).
- R3: While hunting, these pulses never raise any output: passive-level pulses of any width, and active pulses outside both start windows.
- R4: In the data phase at 1x, a short symbol is 24 µs up to but not including 97 µs wide. A long symbol is 97 µs up to but not including 170 µs wide.
- R5: A short pulse gives bit 1 when the line was at the active level and bit 0 when it was passive. A long pulse gives bit 0 when active and bit 1 when passive.
- R6: Bits are shifted in so that the first bit of each group lands in `byte_data[7]`. Every eighth bit raises `byte_valid` for one clock with the finished byte.
- R7: In the data phase, if no edge arrives for 240 µs (60 µs at 4x) after the last edge, `eof_pulse` is raised once and the block returns to hunting.
- R8: In the data phase, a pulse of 2 µs or less is ignored. It produces no bit and no error.
- R9: In the data phase, any other pulse that fits no symbol window raises `err_pulse`, drops the partial byte and returns to hunting. A 3 µs pulse counts as such a pulse.
- R10: A partial byte that is pending at end-of-frame is dropped without a `byte_valid`.
- R11: The interval counter saturates and does not wrap. An active pulse of 712 µs is never taken as a start pulse.
- R12: Each strobe is one clock wide. At most one of `sof_pulse`, `byte_valid`, `eof_pulse` and `err_pulse` is high in any cycle. `byte_valid`, `eof_pulse` and `err_pulse` occur only inside a frame.
- R13: During and right after reset, all strobes, `speed_4x` and `byte_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_in | input | 1 | Synchronised bus line level |
| us_tick | input | 1 | One-clock strobe once per microsecond |
| sof_pulse | output | 1 | Start of frame detected |
| speed_4x | output | 1 | Rate of the current frame (1 = 4x) |
| byte_valid | output | 1 | `byte_data` holds a finished byte |
| byte_data | output | 8 | Decoded byte, first bit in the MSB |
| eof_pulse | output | 1 | Quiet gap ended the frame |
| err_pulse | output | 1 | Unmatched pulse width in the data phase |

## Verification
A rate flag latched wrongly would show at the ports right away. Valid 1x symbols decoded with quarter windows would raise `err_pulse` on the first bit, and the gap strobe would arrive at 60 µs instead of 240 µs. A bit counter or shift register left in the wrong state shows up at the next `byte_valid`: the strobe comes after the wrong number of bits, or the byte has shifted or inverted bits, within one byte time of the fault. A phase register stuck in hunting silences every strobe after a start pulse. A phase register stuck in the data phase gives spurious `err_pulse` or `eof_pulse` on idle-line activity. A wrapping interval counter turns an over-long active pulse into a false `sof_pulse`.

// File: rtl/vpw_pkg.sv
`timescale 1ns/1ps
package vpw_pkg;

  typedef enum logic {
    PH_HUNT = 1'b0,
    PH_DATA = 1'b1
  } vpw_phase_e;

  // Window hits for one measured interval
  typedef struct packed {
    logic sof_1x;
    logic sof_4x;
    logic short_sym;
    logic long_sym;
    logic glitch;
    logic gap;
  } vpw_class_t;

endpackage

// File: rtl/vpw_edge_timer.sv
`timescale 1ns/1ps
module vpw_edge_timer #(
  parameter int   CNT_W    = 9,
  parameter logic IDLE_LVL = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_in,
  input  logic             us_tick,
  output logic             edge_o,
  output logic             level_o,
  output logic [CNT_W-1:0] width_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             line_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;

  // Elapsed ticks including this cycle, held at the top value
  always_comb begin
    if (cnt_q == CNT_MAX) cnt_inc = CNT_MAX;
    else                  cnt_inc = cnt_q + {{(CNT_W-1){1'b0}}, us_tick};
  end

  assign edge_o  = (line_in != line_q);
  assign level_o = line_q;
  assign width_o = cnt_inc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q <= IDLE_LVL;
      cnt_q  <= '0;
    end else begin
      line_q <= line_in;
      cnt_q  <= edge_o ? '0 : cnt_inc;
    end
  end

endmodule

// File: rtl/vpw_symbol_class.sv
`timescale 1ns/1ps
module vpw_symbol_class
  import vpw_pkg::*;
#(
  parameter int CNT_W         = 9,
  parameter int SOF_MIN_US    = 164,
  parameter int SOF_MAX_US    = 245,
  parameter int SHORT_MIN_US  = 24,
  parameter int SHORT_MAX_US  = 97,
  parameter int LONG_MAX_US   = 170,
  parameter int GAP_US        = 240,
  parameter int GLITCH_MAX_US = 2,
  parameter int FAST_DIV      = 4
) (
  input  logic [CNT_W-1:0] width_i,
  input  logic             fast_i,
  output vpw_class_t       cls_o
);

  localparam logic [CNT_W-1:0] GLITCH_LIM = CNT_W'(GLITCH_MAX_US);

  logic [1:0] sof_hit;
  logic [1:0] sh_hit;
  logic [1:0] lg_hit;
  logic [1:0] gap_hit;

  // Index 0: normal rate, index 1: fast rate
  for (genvar s = 0; s < 2; s++) begin : g_rate
    localparam int DIV = (s == 0) ? 1 : FAST_DIV;
    localparam logic [CNT_W-1:0] SOF_LO = CNT_W'(SOF_MIN_US / DIV);
    localparam logic [CNT_W-1:0] SOF_HI = CNT_W'(SOF_MAX_US / DIV);
    localparam logic [CNT_W-1:0] SH_LO  = CNT_W'(SHORT_MIN_US / DIV);
    localparam logic [CNT_W-1:0] SH_HI  = CNT_W'(SHORT_MAX_US / DIV);
    localparam logic [CNT_W-1:0] LG_HI  = CNT_W'(LONG_MAX_US / DIV);
    localparam logic [CNT_W-1:0] GAP_LO = CNT_W'(GAP_US / DIV);

    assign sof_hit[s] = (width_i >= SOF_LO) && (width_i < SOF_HI);
    assign sh_hit[s]  = (width_i >= SH_LO)  && (width_i < SH_HI);
    assign lg_hit[s]  = (width_i >= SH_HI)  && (width_i < LG_HI);
    assign gap_hit[s] = (width_i >= GAP_LO);
  end

  always_comb begin
    cls_o.sof_1x    = sof_hit[0];
    cls_o.sof_4x    = sof_hit[1];
    cls_o.short_sym = fast_i ? sh_hit[1]  : sh_hit[0];
    cls_o.long_sym  = fast_i ? lg_hit[1]  : lg_hit[0];
    cls_o.gap       = fast_i ? gap_hit[1] : gap_hit[0];
    cls_o.glitch    = (width_i <= GLITCH_LIM);
  end

endmodule

// File: rtl/vpw_byte_pack.sv
`timescale 1ns/1ps
module vpw_byte_pack #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_valid,
  input  logic              bit_val,
  input  logic              flush,
  output logic              byte_valid,
  output logic [BYTE_W-1:0] byte_data
);

  localparam int            IDX_W = $clog2(BYTE_W);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(BYTE_W - 1);

  logic [BYTE_W-1:0] sr_q;
  logic [IDX_W-1:0]  idx_q;
  logic [BYTE_W-1:0] sr_next;

  assign sr_next = {sr_q[BYTE_W-2:0], bit_val};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_q       <= '0;
      idx_q      <= '0;
      byte_valid <= 1'b0;
      byte_data  <= '0;
    end else begin
      byte_valid <= 1'b0;
      if (flush) begin
        sr_q  <= '0;
        idx_q <= '0;
      end else if (bit_valid) begin
        if (idx_q == LAST) begin
          byte_data  <= sr_next;
          byte_valid <= 1'b1;
          sr_q       <= '0;
          idx_q      <= '0;
        end else begin
          sr_q  <= sr_next;
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/vpw_symbol_decoder.sv
`timescale 1ns/1ps
module vpw_symbol_decoder
  import vpw_pkg::*;
#(
  parameter logic ACTIVE_LVL    = 1'b1,
  parameter int   CNT_W         = 9,
  parameter int   BYTE_W        = 8,
  parameter int   SOF_MIN_US    = 164,
  parameter int   SOF_MAX_US    = 245,
  parameter int   SHORT_MIN_US  = 24,
  parameter int   SHORT_MAX_US  = 97,
  parameter int   LONG_MAX_US   = 170,
  parameter int   GAP_US        = 240,
  parameter int   GLITCH_MAX_US = 2,
  parameter int   FAST_DIV      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_in,
  input  logic              us_tick,
  output logic              sof_pulse,
  output logic              speed_4x,
  output logic              byte_valid,
  output logic [BYTE_W-1:0] byte_data,
  output logic              eof_pulse,
  output logic              err_pulse
);

  localparam logic IDLE_LVL = ~ACTIVE_LVL;

  logic             edge_w;
  logic             level_w;
  logic [CNT_W-1:0] meas_w;
  vpw_class_t       cls;
  vpw_phase_e       phase_q;
  logic             fast_q;

  logic go_sof_n, go_sof_f, go_eof, go_err, take_bit, bit_val;

  vpw_edge_timer #(
    .CNT_W    (CNT_W),
    .IDLE_LVL (IDLE_LVL)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .line_in (line_in),
    .us_tick (us_tick),
    .edge_o  (edge_w),
    .level_o (level_w),
    .width_o (meas_w)
  );

  vpw_symbol_class #(
    .CNT_W         (CNT_W),
    .SOF_MIN_US    (SOF_MIN_US),
    .SOF_MAX_US    (SOF_MAX_US),
    .SHORT_MIN_US  (SHORT_MIN_US),
    .SHORT_MAX_US  (SHORT_MAX_US),
    .LONG_MAX_US   (LONG_MAX_US),
    .GAP_US        (GAP_US),
    .GLITCH_MAX_US (GLITCH_MAX_US),
    .FAST_DIV      (FAST_DIV)
  ) u_class (
    .width_i (meas_w),
    .fast_i  (fast_q),
    .cls_o   (cls)
  );

  // Decide what the current interval means
  always_comb begin
    go_sof_n = 1'b0;
    go_sof_f = 1'b0;
    go_eof   = 1'b0;
    go_err   = 1'b0;
    take_bit = 1'b0;
    bit_val  = 1'b0;
    if (phase_q == PH_HUNT) begin
      if (edge_w && (level_w == ACTIVE_LVL)) begin
        if (cls.sof_1x)      go_sof_n = 1'b1;
        else if (cls.sof_4x) go_sof_f = 1'b1;
      end
    end else begin
      if (edge_w) begin
        if (cls.short_sym) begin
          take_bit = 1'b1;
          bit_val  = (level_w == ACTIVE_LVL);
        end else if (cls.long_sym) begin
          take_bit = 1'b1;
          bit_val  = (level_w != ACTIVE_LVL);
        end else if (!cls.glitch) begin
          go_err = 1'b1;
        end
      end else if (cls.gap) begin
        go_eof = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q   <= PH_HUNT;
      fast_q    <= 1'b0;
      sof_pulse <= 1'b0;
      eof_pulse <= 1'b0;
      err_pulse <= 1'b0;
    end else begin
      sof_pulse <= go_sof_n | go_sof_f;
      eof_pulse <= go_eof;
      err_pulse <= go_err;
      if (go_sof_n || go_sof_f) begin
        phase_q <= PH_DATA;
        fast_q  <= go_sof_f;
      end else if (go_eof || go_err) begin
        phase_q <= PH_HUNT;
      end
    end
  end

  assign speed_4x = fast_q;

  vpw_byte_pack #(
    .BYTE_W (BYTE_W)
  ) u_pack (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_valid  (take_bit),
    .bit_val    (bit_val),
    .flush      (go_sof_n | go_sof_f | go_eof | go_err),
    .byte_valid (byte_valid),
    .byte_data  (byte_data)
  );

endmodule

// File: rtl/vpw_symbol_decoder_chk.sv
`timescale 1ns/1ps
module vpw_symbol_decoder_chk #(
  parameter logic ACTIVE_LVL = 1'b1,
  parameter int   CNT_W      = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             line_in,
  input logic             sof_pulse,
  input logic             byte_valid,
  input logic             eof_pulse,
  input logic             err_pulse,
  input logic             edge_seen,
  input logic [CNT_W-1:0] width_cnt
);

  logic in_frame;

  always_ff @(posedge clk) begin
    if (!rst_n)                      in_frame <= 1'b0;
    else if (sof_pulse)              in_frame <= 1'b1;
    else if (eof_pulse || err_pulse) in_frame <= 1'b0;
  end

  // R12
  strobes_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sof_pulse, byte_valid, eof_pulse, err_pulse}));

  // R12
  sof_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sof_pulse |=> !sof_pulse);

  // R6
  byte_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |=> !byte_valid);

  // R12
  in_frame_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid || eof_pulse || err_pulse) |-> in_frame);

  // R1
  sof_on_active_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sof_pulse |-> ($past(edge_seen) && ($past(line_in) != ACTIVE_LVL)));

  // R7
  eof_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eof_pulse |-> !$past(edge_seen));

  // R11
  width_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_seen |=> (width_cnt >= $past(width_cnt)));

endmodule

bind vpw_symbol_decoder vpw_symbol_decoder_chk #(
  .ACTIVE_LVL (ACTIVE_LVL),
  .CNT_W      (CNT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .line_in    (line_in),
  .sof_pulse  (sof_pulse),
  .byte_valid (byte_valid),
  .eof_pulse  (eof_pulse),
  .err_pulse  (err_pulse),
  .edge_seen  (edge_w),
  .width_cnt  (meas_w)
);

// File: tb/vpw_symbol_decoder_bench.sv
`timescale 1ns/1ps
module vpw_symbol_decoder_bench;

  localparam logic ACT = 1'b1;
  localparam logic PAS = 1'b0;
  localparam int   TPU = 4;   // clocks per microsecond

  typedef struct packed {
    logic       fast;
    logic [7:0] data;
    logic [7:0] sof_us;
    logic [7:0] sw;
    logic [7:0] lw;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{1'b0, 8'hA5, 8'd200, 8'd64, 8'd128},
    '{1'b0, 8'h00, 8'd164, 8'd24, 8'd169},
    '{1'b0, 8'hFF, 8'd244, 8'd96, 8'd97},
    '{1'b0, 8'h3C, 8'd230, 8'd30, 8'd150},
    '{1'b1, 8'h5A, 8'd50,  8'd16, 8'd32},
    '{1'b1, 8'h81, 8'd41,  8'd6,  8'd41},
    '{1'b1, 8'hC3, 8'd60,  8'd23, 8'd24},
    '{1'b1, 8'h0F, 8'd45,  8'd10, 8'd30}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_in = PAS;
  logic       us_tick = 1'b0;
  logic       sof_pulse, speed_4x, byte_valid, eof_pulse, err_pulse;
  logic [7:0] byte_data;

  int total = 0, bad = 0;
  int cyc = 0, tdiv = 0;
  int sof_n = 0, eof_n = 0, err_n = 0, nb = 0;
  int eof_cyc = 0, mark_cyc = 0;
  logic       last_fast = 1'b0;
  logic [7:0] blog [64];
  logic       nxt = PAS;

  always #2.5 clk = ~clk;

  vpw_symbol_decoder u_vpw_symbol_decoder (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_in    (line_in),
    .us_tick    (us_tick),
    .sof_pulse  (sof_pulse),
    .speed_4x   (speed_4x),
    .byte_valid (byte_valid),
    .byte_data  (byte_data),
    .eof_pulse  (eof_pulse),
    .err_pulse  (err_pulse)
  );

  // Tick source and event log, away from the active edge
  always @(negedge clk) begin
    cyc  = cyc + 1;
    tdiv = (tdiv + 1) % TPU;
    us_tick = (tdiv == 0);
    if (rst_n) begin
      if (sof_pulse) begin sof_n++; last_fast = speed_4x; end
      if (byte_valid) begin
        if (nb < 64) blog[nb] = byte_data;
        nb++;
      end
      if (eof_pulse) begin eof_n++; eof_cyc = cyc; end
      if (err_pulse) err_n++;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic hold(input logic lvl, input int us);
    line_in = lvl;
    repeat (TPU * us) @(negedge clk);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nbits, input int sw, input int lw);
    for (int i = 7; i > 7 - nbits; i--) begin
      int w;
      if (nxt == ACT) w = b[i] ? sw : lw;
      else            w = b[i] ? lw : sw;
      hold(nxt, w);
      nxt = ~nxt;
    end
  endtask

  task automatic start_frame(input int us);
    hold(PAS, 10);
    hold(ACT, us);
    nxt = PAS;
  endtask

  task automatic end_frame(input int idle);
    mark_cyc = cyc;
    hold(PAS, idle);
  endtask

  task automatic sof_probe(input int w, input bit exp_ok, input bit exp_fast, input string tag);
    int s0;
    s0 = sof_n;
    hold(PAS, 20);
    hold(ACT, w);
    hold(PAS, 300);
    chk((sof_n - s0) == int'(exp_ok), tag, sof_n - s0, int'(exp_ok));
    if (exp_ok) chk(last_fast == exp_fast, {tag, " speed"}, last_fast, exp_fast);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL R12 watchdog actual=%0d expected=%0d", cyc, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int s0, e0, r0, b0;
    repeat (6) @(negedge clk);
    // R13 outputs quiet in reset
    chk({sof_pulse, byte_valid, eof_pulse, err_pulse, speed_4x} == 5'b0, "R13 strobes in reset",
        {sof_pulse, byte_valid, eof_pulse, err_pulse, speed_4x}, 0);
    chk(byte_data == 8'h00, "R13 byte_data in reset", byte_data, 0);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    chk({sof_pulse, byte_valid, eof_pulse, err_pulse, speed_4x} == 5'b0, "R13 strobes after reset",
        {sof_pulse, byte_valid, eof_pulse, err_pulse, speed_4x}, 0);

    // Table of single-byte frames at both rates
    for (int v = 0; v < 8; v++) begin
      int el, g;
      s0 = sof_n; e0 = eof_n; r0 = err_n; b0 = nb;
      start_frame(int'(VEC[v].sof_us));
      send_bits(VEC[v].data, 8, int'(VEC[v].sw), int'(VEC[v].lw));
      end_frame(VEC[v].fast ? 80 : 260);
      g = VEC[v].fast ? 60 : 240;
      chk(sof_n == s0 + 1, "R1 R2 start seen", sof_n - s0, 1);
      chk(last_fast == VEC[v].fast, "R2 speed flag", last_fast, VEC[v].fast);
      chk(nb == b0 + 1, "R6 one byte per 8 bits", nb - b0, 1);
      chk(blog[b0] == VEC[v].data, "R4 R5 byte value", blog[b0], VEC[v].data);
      chk(eof_n == e0 + 1, "R7 end of frame", eof_n - e0, 1);
      el = eof_cyc - mark_cyc;
      chk(el >= TPU * (g - 1) && el <= TPU * (g + 1), "R7 gap time", el, TPU * g);
      chk(err_n == r0, "R9 no error", err_n - r0, 0);
    end

    // R6 two bytes, MSB first, in one frame
    b0 = nb;
    start_frame(200);
    send_bits(8'h12, 8, 64, 128);
    send_bits(8'h34, 8, 64, 128);
    end_frame(260);
    chk(nb == b0 + 2, "R6 two bytes", nb - b0, 2);
    chk(blog[b0] == 8'h12, "R6 first byte", blog[b0], 8'h12);
    chk(blog[b0 + 1] == 8'h34, "R6 second byte", blog[b0 + 1], 8'h34);

    // R10 partial byte at end of frame dropped
    b0 = nb; e0 = eof_n;
    start_frame(200);
    send_bits(8'hF0, 4, 64, 128);
    end_frame(260);
    chk(nb == b0, "R10 partial dropped", nb - b0, 0);
    chk(eof_n == e0 + 1, "R10 frame ended", eof_n - e0, 1);
    start_frame(200);
    send_bits(8'h96, 8, 64, 128);
    end_frame(260);
    chk(nb == b0 + 1 && blog[b0] == 8'h96, "R10 next frame clean", blog[b0], 8'h96);

    // R8 glitches inside data phase
    b0 = nb; r0 = err_n;
    start_frame(200);
    hold(PAS, 2);
    hold(ACT, 2);
    send_bits(8'h6B, 8, 64, 128);
    end_frame(260);
    chk(err_n == r0, "R8 glitch no error", err_n - r0, 0);
    chk(nb == b0 + 1 && blog[b0] == 8'h6B, "R8 glitch no bit", blog[b0], 8'h6B);

    // R9 unmatched width in data phase
    b0 = nb; r0 = err_n; e0 = eof_n;
    start_frame(200);
    send_bits(8'hA0, 4, 64, 128);
    hold(PAS, 180);
    hold(ACT, 10);
    hold(PAS, 300);
    chk(err_n == r0 + 1, "R9 error raised", err_n - r0, 1);
    chk(eof_n == e0, "R9 back to hunting", eof_n - e0, 0);
    chk(nb == b0, "R9 partial dropped", nb - b0, 0);

    // R9 3 us pulse at 4x is an error, not a glitch
    r0 = err_n;
    start_frame(50);
    hold(PAS, 3);
    hold(ACT, 10);
    hold(PAS, 100);
    chk(err_n == r0 + 1, "R9 three us error", err_n - r0, 1);

    // R1 R2 R3 start window edges
    sof_probe(163, 1'b0, 1'b0, "R3 below 1x start");
    sof_probe(164, 1'b1, 1'b0, "R1 1x start low edge");
    sof_probe(244, 1'b1, 1'b0, "R1 1x start high edge");
    sof_probe(245, 1'b0, 1'b0, "R3 above 1x start");
    sof_probe(40,  1'b0, 1'b0, "R3 below 4x start");
    sof_probe(41,  1'b1, 1'b1, "R2 4x start low edge");
    sof_probe(60,  1'b1, 1'b1, "R2 4x start high edge");
    sof_probe(61,  1'b0, 1'b0, "R3 above 4x start");

    // R3 passive pulses ignored while hunting
    s0 = sof_n; r0 = err_n;
    hold(ACT, 5);
    hold(PAS, 200);
    hold(ACT, 5);
    hold(PAS, 50);
    chk(sof_n == s0 && err_n == r0, "R3 passive start ignored", sof_n - s0, 0);

    // R11 long active pulse must not wrap into a start window
    s0 = sof_n;
    hold(PAS, 20);
    hold(ACT, 712);
    hold(PAS, 50);
    chk(sof_n == s0, "R11 counter saturates", sof_n - s0, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule